// File: doc/BRIEF.md
# Serial SRAM Device with Transfer Pause

This block is the device end of a byte-organised serial SRAM that sits on an SPI bus in mode 0. The bus master selects it with an active-low select line. It then shifts in an 8-bit command, a 16-bit address where the command calls for one, and then data bytes. For a read, the bytes come back on the serial output. A separate 8-bit status byte can be read or loaded. An active-low pause input lets the master stop a transfer in mid-bit-stream, use the shared serial clock for something else, and resume later at the same bit.

All pins are sampled by the block's own clock `clk`. The serial pins must be synchronous to it, and each high and each low phase of `sck` must last at least two `clk` cycles. The serial output is a data bit plus an enable (`miso_oe`) that a pad or bus multiplexer turns into a tri-state driver. The array holds 2^MEM_AW bytes. A full 32K x 8 device uses MEM_AW = 15, and the default is a smaller array.

The serial lines carry data only as a paced bit stream. There is no back-pressure: the master owns the clock, and the block keeps up with every accepted edge. Pausing is the only way to stall a transfer.

Top module: `sram_spi_slave`

## Requirements
- R1: After reset, and whenever `cs_n` is high, `miso_oe` is low. The status byte resets to 0x00.
- R2: Serial input bits are taken on rising edges of `sck`, most significant bit first. The first bit is the first rising edge after `cs_n` falls.
- R3: `miso` changes only in response to a falling edge of `sck`. `miso_oe` is high only while status or array data are being shifted out.
- R4: Command 0x03 reads and 0x02 writes. Each is followed by a 16-bit address, most significant bit first. Only its low MEM_AW bits select a byte, and the upper bits are ignored.
- R5: During a read or write burst, the address steps by one after each byte. It wraps from 2^MEM_AW-1 to 0 for as long as `cs_n` stays low.
- R6: Command 0x05 shifts the status byte out, repeating it for every further byte. Command 0x01 loads the status byte from the next byte, and any later bytes are ignored.
- R7: Any other command byte leaves `miso_oe` low and changes neither the array nor the status byte until `cs_n` rises.
- R8: A write byte is committed on its eighth rising edge, so a rise of `cs_n` after it keeps it. The bits of an incomplete byte at that rise are dropped.
- R9: A rise of `cs_n` clears the bit position and the command state, so the next selection decodes a new command.
- R10: `hold_n` low forces `miso_oe` low immediately, whatever the state of `sck`.
- R11: A pause takes effect at once if `hold_n` falls while `sck` is low. Otherwise it takes effect at the next falling edge of `sck`. While paused, `sck` and `mosi` have no effect.
- R12: A pause ends only when `hold_n` is high while `sck` is low. The transfer then continues from the exact bit where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data into the device |
| hold_n | input | 1 | Active-low transfer pause |
| miso | output | 1 | Serial data out of the device |
| miso_oe | output | 1 | Drive enable for `miso` (low means high impedance) |

## Verification
The array is exercised by a 128-byte write burst that starts 64 bytes below the top of the array, followed by a read burst over the same span. Every byte value differs from its neighbours, so a missed increment or a wrong wrap point shows up as a mismatch. Addresses with the upper bits set tell true decoding apart from a full 16-bit compare. Write-status is followed by an extra byte, and an unknown command is followed by data, to separate "loaded once" and "ignored" from accidental writes. Pauses are placed both with `sck` low and with `sck` high, in a read and in a write. Garbage clocks and inverted data are applied during each pause, so a design that keeps shifting, or that resumes one bit off, returns or stores a different byte.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PH_OPC,   // collecting command byte
    PH_AHI,   // address high byte
    PH_ALO,   // address low byte
    PH_DATA,  // array burst
    PH_STW,   // status load byte
    PH_STR,   // status shift out
    PH_IDLE   // ignore until deselect
  } phase_t;

  localparam logic [BYTE_W-1:0] CMD_READ    = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_WRITE   = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] CMD_STAT_WR = 8'h01;
endpackage

// File: rtl/sram_spi_hold.sv
module sram_spi_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic held
);
  logic sck_q;

  // Entry and exit both require sck low. A fall with hold_n low is
  // still processed, and the pause starts right after it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n)
        held <= 1'b0;
      else if (!sck)
        held <= !hold_n;
    end
  end

  assign sck_rise = sck  && !sck_q && !held && !cs_n;
  assign sck_fall = !sck &&  sck_q && !held && !cs_n;
endmodule

// File: rtl/sram_spi_array.sv
module sram_spi_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sram_spi_seq.sv
module sram_spi_seq
  import sram_spi_pkg::*;
#(
  parameter int MEM_AW = 11,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [MEM_AW-1:0] addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              miso_bit,
  output logic              drive,
  output logic [CNT_W-1:0]  bit_pos,
  output logic              at_opc
);
  localparam int HI_W = ADDR_W - BYTE_W;

  phase_t              phase;
  logic [BYTE_W-2:0]   sr;
  logic [HI_W-1:0]     hi_q;
  logic                is_read;
  logic [BYTE_W-1:0]   status;
  logic [BYTE_W-1:0]   out_sr;
  logic [BYTE_W-1:0]   byte_in;
  logic                last_bit;
  logic                out_phase;

  assign byte_in   = {sr, mosi};
  assign last_bit  = (bit_pos == CNT_W'(BYTE_W - 1));
  assign out_phase = (phase == PH_STR) || (phase == PH_DATA && is_read);
  assign wr_en     = sck_rise && last_bit && phase == PH_DATA && !is_read;
  assign wr_data   = byte_in;
  assign miso_bit  = out_sr[BYTE_W-1];
  assign at_opc    = (phase == PH_OPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_OPC;
      bit_pos <= '0;
      sr      <= '0;
      hi_q    <= '0;
      addr    <= '0;
      is_read <= 1'b0;
      status  <= '0;
      out_sr  <= '0;
      drive   <= 1'b0;
    end else if (cs_n) begin
      phase   <= PH_OPC;
      bit_pos <= '0;
      drive   <= 1'b0;
    end else begin
      if (sck_rise) begin
        sr      <= byte_in[BYTE_W-2:0];
        bit_pos <= bit_pos + CNT_W'(1);
        if (last_bit) begin
          unique case (phase)
            PH_OPC: begin
              if (byte_in == CMD_READ) begin
                is_read <= 1'b1;
                phase   <= PH_AHI;
              end else if (byte_in == CMD_WRITE) begin
                is_read <= 1'b0;
                phase   <= PH_AHI;
              end else if (byte_in == CMD_STAT_RD) begin
                phase <= PH_STR;
              end else if (byte_in == CMD_STAT_WR) begin
                phase <= PH_STW;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_AHI: begin
              hi_q  <= HI_W'(byte_in);
              phase <= PH_ALO;
            end
            PH_ALO: begin
              addr  <= MEM_AW'({hi_q, byte_in});
              phase <= PH_DATA;
            end
            PH_DATA: addr <= addr + 1'b1;
            PH_STW: begin
              status <= byte_in;
              phase  <= PH_IDLE;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall && out_phase) begin
        drive <= 1'b1;
        if (bit_pos == '0)
          out_sr <= (phase == PH_STR) ? status : rd_data;
        else
          out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sram_spi_slave.sv
module sram_spi_slave
  import sram_spi_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  output logic miso,
  output logic miso_oe
);
  localparam int ADDR_W = 16;

  logic              sck_rise, sck_fall, held;
  logic              wr_en, miso_bit, drive, at_opc;
  logic [MEM_AW-1:0] addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  bit_pos;

  sram_spi_hold u_hold (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .held(held)
  );

  sram_spi_seq #(.MEM_AW(MEM_AW), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .rd_data(rd_data),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .miso_bit(miso_bit),
    .drive(drive), .bit_pos(bit_pos), .at_opc(at_opc)
  );

  sram_spi_array #(.AW(MEM_AW), .DW(BYTE_W)) u_array (
    .clk(clk), .we(wr_en), .waddr(addr), .wdata(wr_data),
    .raddr(addr), .rdata(rd_data)
  );

  assign miso_oe = drive && !held && hold_n && !cs_n;
  assign miso    = miso_bit;
endmodule

// File: rtl/sram_spi_checker.sv
module sram_spi_checker
  import sram_spi_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sck,
  input logic             hold_n,
  input logic             miso,
  input logic             miso_oe,
  input logic             held,
  input logic [CNT_W-1:0] bit_pos,
  input logic             at_opc
);
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso_oe); // R1

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && $past(sck)) |-> $stable(miso)); // R3

  AST_DESELECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_pos == '0 && at_opc)); // R9

  AST_PAUSE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> !miso_oe); // R10

  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> (!$past(sck) && !$past(hold_n))); // R11

  AST_PAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> $stable(bit_pos)); // R11

  AST_PAUSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> ($past(cs_n) || (!$past(sck) && $past(hold_n)))); // R12
endmodule

bind sram_spi_slave sram_spi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
  .miso(miso), .miso_oe(miso_oe), .held(held), .bit_pos(bit_pos),
  .at_opc(at_opc)
);

// File: tb/test_sram_spi_slave.sv
module test_sram_spi_slave;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = 3;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, hold_n;
  logic miso, miso_oe;
  logic oe_any;
  logic [7:0] model [DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sram_spi_slave #(.MEM_AW(AW)) i_sram_spi_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    wait_clk(HALF);
    r = miso;
    if (miso_oe) oe_any = 1'b1;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    oe_any = 1'b0;
    wait_clk(2);
  endtask

  task automatic desel();
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(3);
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    xbyte(op, d);
    xbyte(a[15:8], d);
    xbyte(a[7:0], d);
  endtask

  // Byte with a pause around bit 'at'. Immediate: paused with sck low
  // before the bit. Deferred: hold_n drops with sck high after the bit.
  task automatic xbyte_pause(input logic [7:0] tx, input int at, input bit deferred,
                             input bit rd, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      if (i == at && !deferred) begin
        hold_n = 1'b0;
        wait_clk(1);
        chk("R10 pause forces hi-z", miso_oe, 0);
        for (int k = 0; k < 2; k++) begin
          mosi = ~tx[i];
          sck = 1'b1;
          wait_clk(HALF);
          chk("R11 clocks ignored while paused", miso_oe, 0);
          sck = 1'b0;
          wait_clk(HALF);
        end
        sck = 1'b1;
        wait_clk(HALF);
        hold_n = 1'b1;
        wait_clk(HALF);
        chk("R12 no release while sck high", miso_oe, 0);
        sck = 1'b0;
        wait_clk(HALF);
        if (rd) chk("R12 release with sck low", miso_oe, 1);
      end
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      if (i == at && deferred) begin
        hold_n = 1'b0;
        wait_clk(1);
        chk("R10 pause forces hi-z with sck high", miso_oe, 0);
        sck = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < 2; k++) begin
          mosi = ~mosi;
          sck = 1'b1;
          wait_clk(HALF);
          sck = 1'b0;
          wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
      end else begin
        sck = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic b;
    int base;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1;
    oe_any = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 reset hi-z", miso_oe, 0);

    // R1 / R6: status resets to zero
    sel(); xbyte(8'h05, d); xbyte(8'h00, d); desel();
    chk("R1 status reset value", d, 8'h00);

    // R5: write burst across the top of the array
    base = DEPTH - 64;
    sel();
    cmd_addr(8'h02, 16'(base));
    for (int i = 0; i < 128; i++) begin
      logic [7:0] v;
      v = 8'((i * 29 + 7) & 255);
      xbyte(v, d);
      model[(base + i) % DEPTH] = v;
    end
    chk("R3 no drive during write", oe_any, 0);
    desel();
    chk("R1 hi-z after deselect", miso_oe, 0);

    sel();
    cmd_addr(8'h03, 16'(base));
    for (int i = 0; i < 128; i++) begin
      xbyte(8'h00, d);
      chk("R5 burst readback with wrap", d, model[(base + i) % DEPTH]);
    end
    desel();

    // R4 / R2: upper address bits ignored on read
    sel();
    cmd_addr(8'h03, 16'hF810);
    for (int i = 0; i < 4; i++) begin
      xbyte(8'h00, d);
      chk("R2 R4 read with upper bits set", d, model[16 + i]);
    end
    desel();

    // R4: upper address bits ignored on write
    sel(); cmd_addr(8'h02, 16'h8123); xbyte(8'h5A, d); xbyte(8'hC3, d); desel();
    sel(); cmd_addr(8'h03, 16'h0123); xbyte(8'h00, d);
    chk("R4 write alias", d, 8'h5A);
    xbyte(8'h00, d);
    chk("R4 write alias next", d, 8'hC3);
    desel();

    // R6: status load once, then repeated read
    sel(); xbyte(8'h01, d); xbyte(8'hA5, d); xbyte(8'h3C, d); desel();
    sel(); xbyte(8'h05, d); xbyte(8'h00, d);
    chk("R6 status read", d, 8'hA5);
    xbyte(8'h00, d);
    chk("R6 status repeats", d, 8'hA5);
    desel();

    // R7: unknown command
    sel(); xbyte(8'h0B, d); xbyte(8'h00, d); xbyte(8'h10, d); xbyte(8'h99, d);
    chk("R7 unknown command no drive", oe_any, 0);
    desel();
    sel(); cmd_addr(8'h03, 16'h0010); xbyte(8'h00, d); desel();
    chk("R7 array untouched", d, model[16]);
    sel(); xbyte(8'h05, d); xbyte(8'h00, d); desel();
    chk("R7 status untouched", d, 8'hA5);

    // R8: deselect in mid-byte
    sel(); cmd_addr(8'h02, 16'h0201); xbyte(8'h77, d); desel();
    sel(); cmd_addr(8'h02, 16'h0200); xbyte(8'h11, d);
    for (int i = 3; i >= 0; i--) xbit(1'b0, b);
    desel();
    sel(); cmd_addr(8'h03, 16'h0200); xbyte(8'h00, d);
    chk("R8 completed byte kept", d, 8'h11);
    xbyte(8'h00, d);
    chk("R8 partial byte dropped", d, 8'h77);
    desel();

    // R9: partial command then fresh one
    sel(); for (int i = 0; i < 5; i++) xbit(1'b1, b); desel();
    sel(); xbyte(8'h05, d); xbyte(8'h00, d); desel();
    chk("R9 fresh command after deselect", d, 8'hA5);

    // R10 R11 R12: immediate pause in a read
    model[0] = model[0];
    sel(); cmd_addr(8'h03, 16'h0000);
    xbyte_pause(8'h00, 4, 1'b0, 1'b1, d);
    chk("R12 read resumes at same bit", d, model[0]);
    xbyte(8'h00, d);
    chk("R11 no extra shift while paused", d, model[1]);
    desel();

    // R11: deferred pause in a write
    sel(); cmd_addr(8'h02, 16'h0300);
    xbyte_pause(8'hA6, 5, 1'b1, 1'b0, d);
    xbyte(8'h3D, d);
    desel();
    sel(); cmd_addr(8'h03, 16'h0300);
    xbyte_pause(8'h00, 2, 1'b1, 1'b1, d);
    chk("R11 deferred pause write and read", d, 8'hA6);
    xbyte_pause(8'h00, 6, 1'b0, 1'b1, d);
    chk("R12 second byte after pauses", d, 8'h3D);
    desel();
    chk("R1 idle at end", miso_oe, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule